// File: doc/BRIEF.md
# Host/Target Shared-Memory Mailbox

This block is a mailbox shared by a host and a target processor. Each side has its own read/write port into a 2K-word by 16-bit shared RAM, and both ports can be used in the same cycle. The host puts a command code in word 0 and writes any payload in the words after it. It then rings the target through a control write, and the target sees a level interrupt. The target may instead read a register save area that the host has updated without any notification. When the target finishes, it raises a completion flag, and the host sees a sticky interrupt. The host clears that interrupt with a write-one-to-clear control write.

The host side decodes a wider address bus. A base value selects which window of the host address map reaches the RAM, so several mailboxes can share one host map. A separate peer path gives the target a general-purpose output flag to drive the interrupt input of a neighbouring target. An incoming flag from that neighbour is synchronised and edge-detected into a peer interrupt.

Top module: `mbx_top`

## Requirements
- R1: Both ports read and write every one of the 2^AW words. Read data appears on the port's rdata output one clock after the read request and holds until the next read on that port.
- R2: A host access reaches the RAM only when host address bits [HAW-1:AW] equal `host_base`. A host write outside the window changes no RAM word. A host read outside the window returns 0.
- R3: A host control write with bit 0 set raises `tgt_irq` on the next clock. `tgt_irq` then stays high until the target clears it.
- R4: The target clears `tgt_irq` in either of two ways: a target control write with bit 0 set, or a target read of word 0. A target read of any other word leaves `tgt_irq` unchanged.
- R5: When a raise and a clear of `tgt_irq` occur in the same cycle, `tgt_irq` ends up high.
- R6: Host data writes, including writes to the register save area, never change `tgt_irq`.
- R7: A target control write with bit 1 set raises `host_irq`, which is sticky. A host control write with bit 1 set clears it. When the raise and the clear occur in the same cycle, `host_irq` stays high.
- R8: When both ports write the same word in one cycle, the host data is stored and `collision` is high for exactly the next cycle. Writes to different words in one cycle both land, and `collision` stays low.
- R9: Every target control write copies its bit 2 to `peer_flag_out`. A rising edge on `peer_flag_in` sets `peer_irq` within 4 clocks. A target control write with bit 3 set clears `peer_irq`.
- R10: After reset, `tgt_irq`, `host_irq`, `peer_irq`, `peer_flag_out`, `collision` and both rdata outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_base | input | HAW-AW | Window base compared with the upper host address bits |
| h_en | input | 1 | Host memory access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HAW | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data |
| h_ctl_we | input | 1 | Host control write strobe |
| h_ctl_wdata | input | 2 | Bit 0 rings the target; bit 1 clears host_irq |
| t_en | input | 1 | Target memory access request |
| t_we | input | 1 | Target write (1) or read (0) |
| t_addr | input | AW | Target address |
| t_wdata | input | DW | Target write data |
| t_rdata | output | DW | Target read data |
| t_ctl_we | input | 1 | Target control write strobe |
| t_ctl_wdata | input | 4 | Bit 0 acks tgt_irq, bit 1 raises host_irq, bit 2 sets the peer flag level, bit 3 clears peer_irq |
| peer_flag_in | input | 1 | Flag from the neighbouring target |
| tgt_irq | output | 1 | Interrupt to the target |
| host_irq | output | 1 | Interrupt to the host |
| peer_irq | output | 1 | Interrupt raised by the neighbour's flag |
| peer_flag_out | output | 1 | Flag to the neighbouring target |
| collision | output | 1 | One-cycle pulse after a same-word double write |

## Verification
If an interrupt register took a wrong value, the fault would show on `tgt_irq` or `host_irq` one clock after the offending control write or word-0 read. It would then persist, because both bits hold until explicitly cleared. A wrong window decode or a wrong write priority would stay hidden until a later read of the affected word, which returns stale data two clocks after the write at the earliest. The full sweeps therefore read back every word from the opposite port. A fault in the peer synchroniser would show as a missing or late `peer_irq` four clocks after the loop-back flag rises.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Control word bit positions (host side)
    localparam int unsigned HC_RING     = 0;
    localparam int unsigned HC_DONE_CLR = 1;
    // Control word bit positions (target side)
    localparam int unsigned TC_ACK      = 0;
    localparam int unsigned TC_DONE     = 1;
    localparam int unsigned TC_PEER     = 2;
    localparam int unsigned TC_PEER_CLR = 3;

    typedef struct packed {
        logic       tgt_irq;
        logic       host_irq;
        logic       peer_out;
        logic [1:0] sync;
        logic       sync_prev;
        logic       peer_irq;
    } irq_state_t;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          clash
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] a_rdata_d, a_rdata_q, b_rdata_d, b_rdata_q;
    logic          clash_d, clash_q;
    logic          same_wr;

    // Port a (host) wins a same-word double write
    assign same_wr = a_en && a_we && b_en && b_we && (a_addr == b_addr);

    always_comb begin
        a_rdata_d = a_rdata_q;
        b_rdata_d = b_rdata_q;
        if (a_en && !a_we) a_rdata_d = mem[a_addr];
        if (b_en && !b_we) b_rdata_d = mem[b_addr];
        clash_d = same_wr;
    end

    always_ff @(posedge clk) begin
        if (a_en && a_we)             mem[a_addr] <= a_wdata;
        if (b_en && b_we && !same_wr) mem[b_addr] <= b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata_q <= '0;
            b_rdata_q <= '0;
            clash_q   <= 1'b0;
        end else begin
            a_rdata_q <= a_rdata_d;
            b_rdata_q <= b_rdata_d;
            clash_q   <= clash_d;
        end
    end

    assign a_rdata = a_rdata_q;
    assign b_rdata = b_rdata_q;
    assign clash   = clash_q;

    // Clash pulse is exactly one cycle unless the double write repeats
    p_clash_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clash_q && !same_wr |=> !clash_q);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_ctl_we,
    input  logic [1:0] h_ctl_wdata,
    input  logic       t_ctl_we,
    input  logic [3:0] t_ctl_wdata,
    input  logic       t_rd_word0,
    input  logic       peer_in,
    output logic       tgt_irq,
    output logic       host_irq,
    output logic       peer_irq,
    output logic       peer_out
);
    irq_state_t st_d, st_q;
    logic ring, ack, done, done_clr;

    assign ring     = h_ctl_we && h_ctl_wdata[HC_RING];
    assign done_clr = h_ctl_we && h_ctl_wdata[HC_DONE_CLR];
    assign ack      = (t_ctl_we && t_ctl_wdata[TC_ACK]) || t_rd_word0;
    assign done     = t_ctl_we && t_ctl_wdata[TC_DONE];

    always_comb begin
        st_d = st_q;
        // Clear first, set last: a simultaneous set wins
        if (ack)      st_d.tgt_irq  = 1'b0;
        if (ring)     st_d.tgt_irq  = 1'b1;
        if (done_clr) st_d.host_irq = 1'b0;
        if (done)     st_d.host_irq = 1'b1;
        if (t_ctl_we) st_d.peer_out = t_ctl_wdata[TC_PEER];
        st_d.sync      = {st_q.sync[0], peer_in};
        st_d.sync_prev = st_q.sync[1];
        if (t_ctl_we && t_ctl_wdata[TC_PEER_CLR]) st_d.peer_irq = 1'b0;
        if (st_q.sync[1] && !st_q.sync_prev)      st_d.peer_irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_irq  = st_q.tgt_irq;
    assign host_irq = st_q.host_irq;
    assign peer_irq = st_q.peer_irq;
    assign peer_out = st_q.peer_out;

    p_ring_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ring |=> tgt_irq);
    p_tgt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_irq && !ack |=> tgt_irq);
    p_tgt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_irq && !ring |=> !tgt_irq);
    p_host_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq && !done_clr |=> host_irq);
    p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> host_irq);
endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
    parameter int unsigned AW  = 11,
    parameter int unsigned DW  = 16,
    parameter int unsigned HAW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HAW-AW-1:0] host_base,
    input  logic              h_en,
    input  logic              h_we,
    input  logic [HAW-1:0]    h_addr,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    input  logic              h_ctl_we,
    input  logic [1:0]        h_ctl_wdata,
    input  logic              t_en,
    input  logic              t_we,
    input  logic [AW-1:0]     t_addr,
    input  logic [DW-1:0]     t_wdata,
    output logic [DW-1:0]     t_rdata,
    input  logic              t_ctl_we,
    input  logic [3:0]        t_ctl_wdata,
    input  logic              peer_flag_in,
    output logic              tgt_irq,
    output logic              host_irq,
    output logic              peer_irq,
    output logic              peer_flag_out,
    output logic              collision
);
    logic          h_hit, t_rd0;
    logic [DW-1:0] ram_h_rdata;
    logic          miss_rd_d, miss_rd_q;

    assign h_hit = h_en && (h_addr[HAW-1:AW] == host_base);
    assign t_rd0 = t_en && !t_we && (t_addr == '0);

    // Remember whether the latest host read fell outside the window
    always_comb begin
        miss_rd_d = miss_rd_q;
        if (h_en && !h_we) miss_rd_d = !h_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) miss_rd_q <= 1'b0;
        else        miss_rd_q <= miss_rd_d;
    end

    assign h_rdata = miss_rd_q ? '0 : ram_h_rdata;

    mbx_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (h_hit),
        .a_we    (h_we),
        .a_addr  (h_addr[AW-1:0]),
        .a_wdata (h_wdata),
        .a_rdata (ram_h_rdata),
        .b_en    (t_en),
        .b_we    (t_we),
        .b_addr  (t_addr),
        .b_wdata (t_wdata),
        .b_rdata (t_rdata),
        .clash   (collision)
    );

    mbx_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_ctl_we    (h_ctl_we),
        .h_ctl_wdata (h_ctl_wdata),
        .t_ctl_we    (t_ctl_we),
        .t_ctl_wdata (t_ctl_wdata),
        .t_rd_word0  (t_rd0),
        .peer_in     (peer_flag_in),
        .tgt_irq     (tgt_irq),
        .host_irq    (host_irq),
        .peer_irq    (peer_irq),
        .peer_out    (peer_flag_out)
    );

    p_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_hit && h_we && t_en && t_we && h_addr[AW-1:0] == t_addr) |=> collision);
    p_no_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_hit && h_we && t_en && t_we && h_addr[AW-1:0] == t_addr) |=> !collision);
    p_word0_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_rd0 && !(h_ctl_we && h_ctl_wdata[0]) |=> !tgt_irq);
endmodule

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
    localparam int unsigned AW = 11, DW = 16, HAW = 16;
    localparam int unsigned DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [HAW-AW-1:0] host_base = 5'd3;
    logic h_en = 0, h_we = 0, h_ctl_we = 0, t_en = 0, t_we = 0, t_ctl_we = 0;
    logic [HAW-1:0] h_addr = '0;
    logic [AW-1:0]  t_addr = '0;
    logic [DW-1:0]  h_wdata = '0, t_wdata = '0, h_rdata, t_rdata;
    logic [1:0] h_ctl_wdata = '0;
    logic [3:0] t_ctl_wdata = '0;
    logic peer_flag_in, tgt_irq, host_irq, peer_irq, peer_flag_out, collision;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;
    assign peer_flag_in = peer_flag_out;   // loop-back to a virtual peer

    mbx_top #(.AW(AW), .DW(DW), .HAW(HAW)) dut (.*);

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'(a * 40503 + salt) ^ 16'h1234;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        h_en = 0; h_we = 0; t_en = 0; t_we = 0; h_ctl_we = 0; t_ctl_we = 0;
    endtask

    task automatic hwr(logic [HAW-1:0] a, logic [DW-1:0] d);
        h_en = 1; h_we = 1; h_addr = a; h_wdata = d; cyc();
    endtask
    task automatic hrd(logic [HAW-1:0] a);
        h_en = 1; h_we = 0; h_addr = a; cyc();
    endtask
    task automatic twr(logic [AW-1:0] a, logic [DW-1:0] d);
        t_en = 1; t_we = 1; t_addr = a; t_wdata = d; cyc();
    endtask
    task automatic trd(logic [AW-1:0] a);
        t_en = 1; t_we = 0; t_addr = a; cyc();
    endtask
    task automatic hctl(logic [1:0] v);
        h_ctl_we = 1; h_ctl_wdata = v; cyc();
    endtask
    task automatic tctl(logic [3:0] v);
        t_ctl_we = 1; t_ctl_wdata = v; cyc();
    endtask

    function automatic logic [HAW-1:0] win(int a);
        return {host_base, AW'(a)};
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #23 rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 tgt_irq", 16'(tgt_irq), 0);
        chk("R10 host_irq", 16'(host_irq), 0);
        chk("R10 peer_irq", 16'(peer_irq), 0);
        chk("R10 peer_flag_out", 16'(peer_flag_out), 0);
        chk("R10 collision", 16'(collision), 0);
        chk("R10 h_rdata", h_rdata, 0);
        chk("R10 t_rdata", t_rdata, 0);
        @(negedge clk);

        // R1 full sweep host->target
        for (int a = 0; a < DEPTH; a++) hwr(win(a), pat(a, 0));
        for (int a = 0; a < DEPTH; a++) begin
            trd(AW'(a)); chk("R1 target read", t_rdata, pat(a, 0));
        end
        // R1 full sweep target->host
        for (int a = 0; a < DEPTH; a++) twr(AW'(a), pat(a, 7));
        for (int a = 0; a < DEPTH; a++) begin
            hrd(win(a)); chk("R1 host read", h_rdata, pat(a, 7));
        end
        cyc(); chk("R1 rdata holds", h_rdata, pat(DEPTH - 1, 7));

        // R2 window decode: other bases ignored
        for (int b = 0; b < (1 << (HAW - AW)); b++) begin
            if (b != 3) begin
                hwr({5'(b), AW'(b + 5)}, 16'hDEAD);
                trd(AW'(b + 5)); chk("R2 outside write ignored", t_rdata, pat(b + 5, 7));
                hrd({5'(b), AW'(b + 5)}); chk("R2 outside read zero", h_rdata, 0);
            end
        end
        host_base = 5'd9;
        hwr({5'd9, 11'd40}, 16'hBEEF);
        trd(11'd40); chk("R2 new base write", t_rdata, 16'hBEEF);
        host_base = 5'd3;

        // R6 register-area writes do not ring
        for (int a = 1000; a < 1032; a++) hwr(win(a), 16'(a));
        chk("R6 no ring", 16'(tgt_irq), 0);
        hwr(win(0), 16'h0005);  // command code
        chk("R6 command write alone", 16'(tgt_irq), 0);

        // R3 ring and hold
        hctl(2'b01); chk("R3 ring", 16'(tgt_irq), 1);
        repeat (5) cyc();
        chk("R3 held", 16'(tgt_irq), 1);
        // R4 other read keeps, word0 read clears
        trd(11'd1001); chk("R4 other read keeps", 16'(tgt_irq), 1);
        chk("R4 reg area data", t_rdata, 16'd1001);
        trd(11'd0); chk("R4 word0 clears", 16'(tgt_irq), 0);
        chk("R4 command code", t_rdata, 16'h0005);
        hctl(2'b01); tctl(4'b0001); chk("R4 ctl ack clears", 16'(tgt_irq), 0);

        // R5 simultaneous set and clear
        h_ctl_we = 1; h_ctl_wdata = 2'b01; t_ctl_we = 1; t_ctl_wdata = 4'b0001; cyc();
        chk("R5 ctl ack vs ring", 16'(tgt_irq), 1);
        h_ctl_we = 1; h_ctl_wdata = 2'b01; t_en = 1; t_we = 0; t_addr = '0; cyc();
        chk("R5 word0 vs ring", 16'(tgt_irq), 1);
        tctl(4'b0001);

        // R7 completion flag
        tctl(4'b0010); chk("R7 done", 16'(host_irq), 1);
        repeat (3) cyc(); chk("R7 sticky", 16'(host_irq), 1);
        hctl(2'b00); chk("R7 zero write keeps", 16'(host_irq), 1);
        hctl(2'b10); chk("R7 w1c", 16'(host_irq), 0);
        h_ctl_we = 1; h_ctl_wdata = 2'b10; t_ctl_we = 1; t_ctl_wdata = 4'b0010; cyc();
        chk("R7 set wins", 16'(host_irq), 1);
        hctl(2'b10);

        // R8 collisions
        h_en = 1; h_we = 1; h_addr = win(77); h_wdata = 16'hAAAA;
        t_en = 1; t_we = 1; t_addr = 11'd77; t_wdata = 16'h5555; cyc();
        chk("R8 collision pulse", 16'(collision), 1);
        trd(11'd77); chk("R8 collision gone", 16'(collision), 0);
        chk("R8 host wins", t_rdata, 16'hAAAA);
        h_en = 1; h_we = 1; h_addr = win(80); h_wdata = 16'h1111;
        t_en = 1; t_we = 1; t_addr = 11'd81; t_wdata = 16'h2222; cyc();
        chk("R8 distinct no collision", 16'(collision), 0);
        trd(11'd80); chk("R8 host word", t_rdata, 16'h1111);
        hrd(win(81)); chk("R8 target word", h_rdata, 16'h2222);

        // R9 peer flag loop-back
        tctl(4'b0100); chk("R9 flag out", 16'(peer_flag_out), 1);
        repeat (4) cyc(); chk("R9 peer irq", 16'(peer_irq), 1);
        tctl(4'b1100); chk("R9 peer clear", 16'(peer_irq), 0);
        repeat (5) cyc(); chk("R9 no edge no irq", 16'(peer_irq), 0);
        tctl(4'b0000); chk("R9 flag low", 16'(peer_flag_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule